// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a 64-bit packed-data execution unit. Each operand word is split into independent lanes of 8, 16 or 32 bits, and a single operation is applied to every lane at once. The unit offers lane-wise addition and subtraction in three flavours: wrap-around, signed saturation and unsigned saturation. It also offers a lane-wise equality compare that produces an all-ones or all-zeros mask per lane, and four full-width bitwise operations.

With these operations, branch-free pixel kernels take only a few steps. Absolute frame difference is two unsigned-saturated subtractions followed by an OR. A masked overlay is a compare, then an AND, then an AND-NOT, then an OR.

Operations enter on a valid/ready stream, and the result leaves on a second valid/ready stream one register stage later. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operation is accepted. Reset is synchronous and active high.

Top module: `simd_sat_alu`

## Requirements
- R1: Opcodes 0x0 (add) and 0x4 (subtract, a minus b) wrap modulo the lane width, and no carry or borrow crosses a lane boundary.
- R2: Opcodes 0x1 (add) and 0x5 (subtract) treat lanes as two's complement and clamp a result above the lane maximum to 0111..1, and a result below the lane minimum to 1000..0.
- R3: Opcodes 0x2 (add) and 0x6 (subtract) treat lanes as unsigned. An add that overflows gives all ones, and a subtract that would go negative gives zero.
- R4: Opcode 0x8 sets every bit of a lane when the lanes of a and b are equal, and clears every bit of that lane otherwise.
- R5: Opcodes 0xC (a AND b), 0xD ((NOT a) AND b), 0xE (a OR b) and 0xF (a XOR b) act on all 64 bits. Their result does not depend on which of the lane codes 00, 01 or 10 is given.
- R6: `in_size` selects the lane width: 00 gives 8 bits, 01 gives 16 bits and 10 gives 32 bits. Code 11 is reserved and gives a zero result for every opcode.
- R7: Unassigned opcodes (0x3, 0x7, 0x9, 0xA, 0xB) give a zero result.
- R8: An operation accepted on a clock edge appears on `out_data` with `out_valid` high right after that edge. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` is stable and `in_ready` is low.
- R10: After reset, `out_valid` is low and `out_data` is zero.
- R11: For unsigned 8-bit lanes, the OR of the results of opcode 0x6 applied to (a, b) and to (b, a) equals the absolute difference of each lane pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 4 | Opcode |
| in_size | input | 2 | Lane width code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result word |

## Verification
The bench targets carries at lane edges. A design that leaks a carry corrupts the neighbouring lane, for example 0x00FF plus 0x0001 in 8-bit lanes giving 0x0100. It also drives signed operands to both extremes. A saturation that compared only the carry-out would clamp -128 + -1 in the wrong direction, or would wrap 0x7F + 1 to 0x80. The bench further checks unsigned subtract underflow, where a wrapping result would break the absolute-difference idiom, and the reserved lane code and unassigned opcodes, which must not leak data. Finally, it stalls the output to catch a register that overwrites a held result or accepts input while full.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    SAT_WRAP  = 2'd0,
    SAT_SIGN  = 2'd1,
    SAT_UNSG  = 2'd2,
    SAT_NONE  = 2'd3
  } sat_mode_e;

  typedef enum logic [1:0] {
    LOG_AND  = 2'd0,
    LOG_ANDN = 2'd1,
    LOG_OR   = 2'd2,
    LOG_XOR  = 2'd3
  } logic_sel_e;

  typedef enum logic [1:0] {
    KIND_ZERO  = 2'd0,
    KIND_ARITH = 2'd1,
    KIND_CMP   = 2'd2,
    KIND_LOGIC = 2'd3
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic       sub;
    sat_mode_e  mode;
    logic_sel_e lsel;
  } op_ctrl_t;

  localparam int unsigned NUM_WIDTHS = 3;
  localparam logic [1:0]  SIZE_RSVD  = 2'b11;

  function automatic op_ctrl_t decode_op(input logic [3:0] op);
    op_ctrl_t c;
    c.kind = KIND_ZERO;
    c.sub  = op[2];
    c.mode = sat_mode_e'(op[1:0]);
    c.lsel = logic_sel_e'(op[1:0]);
    if (!op[3] && op[1:0] != 2'b11) c.kind = KIND_ARITH;
    else if (op == 4'h8)            c.kind = KIND_CMP;
    else if (op[3:2] == 2'b11)      c.kind = KIND_LOGIC;
    return c;
  endfunction
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          sub,
  input  sat_mode_e     mode,
  output logic [LW-1:0] res,
  output logic          eq
);
  localparam logic [LW-1:0] S_MAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] S_MIN = {1'b1, {(LW-1){1'b0}}};

  logic [LW:0]        u_res;
  logic signed [LW:0] s_res;

  always_comb begin
    u_res = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    s_res = sub ? ($signed({a[LW-1], a}) - $signed({b[LW-1], b}))
                : ($signed({a[LW-1], a}) + $signed({b[LW-1], b}));
    res = u_res[LW-1:0];
    case (mode)
      SAT_UNSG: if (u_res[LW]) res = sub ? '0 : '1;
      SAT_SIGN: if (s_res[LW] != s_res[LW-1]) res = s_res[LW] ? S_MIN : S_MAX;
      default:  res = u_res[LW-1:0];
    endcase
  end

  assign eq = (a == b);
endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group
  import simd_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  sat_mode_e     mode,
  output logic [DW-1:0] arith,
  output logic [DW-1:0] mask
);
  localparam int unsigned NL = DW / LW;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic lane_eq;
    simd_lane #(.LW(LW)) u_lane (
      .a    (a[i*LW +: LW]),
      .b    (b[i*LW +: LW]),
      .sub  (sub),
      .mode (mode),
      .res  (arith[i*LW +: LW]),
      .eq   (lane_eq)
    );
    assign mask[i*LW +: LW] = {LW{lane_eq}};
  end
endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
  import simd_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic_sel_e    sel,
  output logic [DW-1:0] y
);
  always_comb begin
    case (sel)
      LOG_AND:  y = a & b;
      LOG_ANDN: y = ~a & b;
      LOG_OR:   y = a | b;
      default:  y = a ^ b;
    endcase
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_pkg::*;
#(
  parameter int unsigned DW     = 64,
  parameter int unsigned MIN_LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  op_ctrl_t      ctrl;
  logic [DW-1:0] arith_w [NUM_WIDTHS];
  logic [DW-1:0] mask_w  [NUM_WIDTHS];
  logic [DW-1:0] logic_y;
  logic [DW-1:0] result;
  logic          accept;

  assign ctrl = decode_op(in_op);

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    simd_lane_group #(.DW(DW), .LW(MIN_LW << g)) u_grp (
      .a     (in_a),
      .b     (in_b),
      .sub   (ctrl.sub),
      .mode  (ctrl.mode),
      .arith (arith_w[g]),
      .mask  (mask_w[g])
    );
  end

  simd_logic_unit #(.DW(DW)) u_logic (
    .a   (in_a),
    .b   (in_b),
    .sel (ctrl.lsel),
    .y   (logic_y)
  );

  always_comb begin
    result = '0;
    if (in_size != SIZE_RSVD) begin
      case (ctrl.kind)
        KIND_ARITH: result = arith_w[in_size];
        KIND_CMP:   result = mask_w[in_size];
        KIND_LOGIC: result = logic_y;
        default:    result = '0;
      endcase
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R9
  AST_RSVD_SIZE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (accept && in_size == SIZE_RSVD) |=> (out_data == '0)); // R6
  AST_UNUSED_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (accept && in_op inside {4'h3, 4'h7, 4'h9, 4'hA, 4'hB}) |=> (out_data == '0)); // R7
  AST_CMP_SELF_ONES: assert property (@(posedge clk) disable iff (rst)
    (accept && in_op == 4'h8 && in_size != SIZE_RSVD && in_a == in_b) |=> (out_data == '1)); // R4
  AST_USUB_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (accept && in_op == 4'h6 && in_a == '0) |=> (out_data == '0)); // R3
endmodule

// File: tb/simd_sat_alu_test.sv
module simd_sat_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  simd_sat_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v, input longint lo, input longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] sz,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    int w;
    longint m, hi, lo, ua, ub, sa, sb, v;
    if (sz == 2'b11) return '0;
    case (op)
      4'hC: return a & b;
      4'hD: return ~a & b;
      4'hE: return a | b;
      4'hF: return a ^ b;
      default: ;
    endcase
    if (!(op inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h8})) return '0;
    w  = 8 << sz;
    m  = (longint'(1) << w) - 1;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -hi - 1;
    r  = '0;
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'(a >> (i * w)) & m;
      ub = longint'(b >> (i * w)) & m;
      sa = (ua > hi) ? ua - m - 1 : ua;
      sb = (ub > hi) ? ub - m - 1 : ub;
      case (op)
        4'h0: v = ua + ub;
        4'h1: v = clampv(sa + sb, lo, hi);
        4'h2: v = (ua + ub > m) ? m : ua + ub;
        4'h4: v = ua - ub;
        4'h5: v = clampv(sa - sb, lo, hi);
        4'h6: v = (ua < ub) ? 0 : ua - ub;
        default: v = (ua == ub) ? m : 0;
      endcase
      r = r | (64'(v & m) << (i * w));
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [1:0] sz);
    if (sz == 2'b11) return "R6";
    case (op)
      4'h0, 4'h4: return "R1";
      4'h1, 4'h5: return "R2";
      4'h2, 4'h6: return "R3";
      4'h8: return "R4";
      4'hC, 4'hD, 4'hE, 4'hF: return "R5";
      default: return "R7";
    endcase
  endfunction

  // Drive at a falling edge, accepted at the next rising edge, sampled at the following falling edge.
  task automatic run_op(input logic [3:0] op, input logic [1:0] sz,
                        input logic [63:0] a, input logic [63:0] b, output logic [63:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_size = sz; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 out_valid after accept", {63'd0, out_valid}, 64'd1);
    r = out_data;
  endtask

  task automatic exp_op(input string tag, input logic [3:0] op, input logic [1:0] sz,
                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    run_op(op, sz, a, b, r);
    check(tag, r, model(op, sz, a, b));
  endtask

  function automatic logic [63:0] rand_word();
    logic [63:0] w;
    for (int k = 0; k < 8; k++) begin
      case ($urandom_range(0, 5))
        0: w[k*8 +: 8] = 8'h00;
        1: w[k*8 +: 8] = 8'hFF;
        2: w[k*8 +: 8] = 8'h7F;
        3: w[k*8 +: 8] = 8'h80;
        4: w[k*8 +: 8] = 8'h01;
        default: w[k*8 +: 8] = 8'($urandom);
      endcase
    end
    return w;
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] r1, r2, r3, ab, bb, exp_abs, held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 out_valid at reset", {63'd0, out_valid}, 64'd0);
    check("R10 out_data at reset", out_data, 64'd0);

    // R1: no carry across lanes
    exp_op("R1 carry stays in byte", 4'h0, 2'b00, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001);
    run_op(4'h0, 2'b01, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, r1);
    check("R1 carry stays in halfword", r1, 64'h0);
    exp_op("R1 borrow stays in word", 4'h4, 2'b10, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
    // R2: signed saturation both directions
    run_op(4'h1, 2'b00, 64'h7F80_7F80_0000_0000, 64'h01FF_7F80_0000_0000, r1);
    check("R2 signed add clamp", r1, 64'h7F80_7F80_0000_0000);
    exp_op("R2 signed sub clamp 16", 4'h5, 2'b01, 64'h8000_7FFF_0001_FFFF, 64'h0001_FFFF_0002_0001);
    exp_op("R2 signed add clamp 32", 4'h1, 2'b10, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF);
    // R3: unsigned saturation
    run_op(4'h2, 2'b00, 64'hFF10_0000_0000_0000, 64'h01F0_0000_0000_0000, r1);
    check("R3 unsigned add clamp", r1, 64'hFFFF_0000_0000_0000);
    run_op(4'h6, 2'b00, 64'h0010_0000_0000_0005, 64'h0120_0000_0000_0003, r1);
    check("R3 unsigned sub floor", r1, 64'h0000_0000_0000_0002);
    // R4: compare mask
    run_op(4'h8, 2'b01, 64'h1234_5678_0000_FFFF, 64'h1234_5679_0000_FFFE, r1);
    check("R4 compare mask", r1, 64'hFFFF_0000_FFFF_0000);
    // R5: logic independent of lane code
    ab = 64'hF0F0_1234_AAAA_0F0F; bb = 64'hFF00_4321_5555_FFFF;
    run_op(4'hD, 2'b00, ab, bb, r1);
    run_op(4'hD, 2'b10, ab, bb, r2);
    check("R5 andn lane-code independent", r2, r1);
    check("R5 andn value", r1, ~ab & bb);
    // R6: reserved lane code
    run_op(4'h0, 2'b11, 64'h1111_2222_3333_4444, 64'h1, r1);
    check("R6 reserved size zero", r1, 64'h0);
    run_op(4'hE, 2'b11, ab, bb, r1);
    check("R6 reserved size logic zero", r1, 64'h0);
    // R7: unassigned opcodes
    run_op(4'hA, 2'b00, ab, bb, r1);
    check("R7 unassigned opcode zero", r1, 64'h0);

    // R11: absolute difference idiom through the unit itself
    ab = 64'h10F0_0080_FF01_7F20; bb = 64'hF010_8000_01FF_207F;
    exp_abs = '0;
    for (int k = 0; k < 8; k++) begin
      int x, y;
      x = int'(ab[k*8 +: 8]); y = int'(bb[k*8 +: 8]);
      exp_abs[k*8 +: 8] = 8'((x > y) ? x - y : y - x);
    end
    run_op(4'h6, 2'b00, ab, bb, r1);
    run_op(4'h6, 2'b00, bb, ab, r2);
    run_op(4'hE, 2'b00, r1, r2, r3);
    check("R11 absolute difference", r3, exp_abs);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 4'h0; in_size = 2'b00; in_a = 64'h0102_0304_0506_0708; in_b = 64'h0101_0101_0101_0101;
    held = model(4'h0, 2'b00, in_a, in_b);
    @(negedge clk);
    check("R8 valid under stall", {63'd0, out_valid}, 64'd1);
    check("R9 first result", out_data, held);
    in_op = 4'hF; in_a = 64'hDEAD_BEEF_0000_1111; in_b = 64'h1234_5678_9ABC_DEF0;
    check("R9 in_ready low when full", {63'd0, in_ready}, 64'd0);
    repeat (2) @(negedge clk);
    check("R9 held valid", {63'd0, out_valid}, 64'd1);
    check("R9 held data", out_data, held);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second result after release", out_data, 64'hDEAD_BEEF_0000_1111 ^ 64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    check("R8 valid drops when drained", {63'd0, out_valid}, 64'd0);

    // Constrained random mix over all opcodes and lane codes
    for (int it = 0; it < 400; it++) begin
      logic [3:0] op;
      logic [1:0] sz;
      logic [63:0] a, b;
      op = 4'($urandom_range(0, 15));
      sz = ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      a  = rand_word();
      b  = ($urandom_range(0, 3) == 0) ? a : rand_word();
      exp_op(tag_of(op, sz), op, sz, a, b);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule